// File: doc/BRIEF.md
# Host Port Access Strobe Sequencer

This block is a host-side bus master for a DSP-style parallel host port. A command interface gives it one access at a time: a read/write direction, a 2-bit control code, a halfword-select bit and, for writes, a data word. The block drives the chip-select and two data-strobe lines, an address-strobe and the select group, and it drives the data bus only during writes. It then waits for the target's active-low ready. On a read it captures the bus, and at the end it reports completion with a one-cycle pulse.

The target sees an effective strobe that is low only when chip-select is low and exactly one of the two data strobes is low. The formula is: effective strobe = NOT(A XOR B) OR chip-select. All setup, hold, pulse-width and recovery intervals are counted in host clock cycles and set by parameters. The integrator derives these counts from the target's clock period. If ready never arrives, an optional timeout ends the access and flags an error.

Top module: `hpa_strobe_seq`

## Requirements
- R1: While reset is held and after it is released, with no request, cs_n, ds_a_n, ds_b_n and as_n are 1, bus_oe is 0, done is 0 and req_ready is 1.
- R2: The effective strobe is NOT(ds_a_n XOR ds_b_n) OR cs_n. With STB_SEL=0, only ds_a_n pulses during an access and ds_b_n stays 1.
- R3: sel_ctl, sel_rnw and sel_half carry the accepted command when the effective strobe falls. They do not change while cs_n is low.
- R4: as_n is 0 whenever the effective strobe is low, and it has already fallen when the effective strobe falls.
- R5: The effective strobe stays low for at least LOW_MIN host cycles.
- R6: The effective strobe rises only after rdy_n has been seen low, and it stays low for at least RDY_HOLD cycles while rdy_n is low. A timeout abort is the one exception.
- R7: Between two accesses the effective strobe is high for at least HIGH_MIN cycles. req_ready is 1 only in the idle state. Back-to-back requests give a high gap of exactly DATA_HOLD+HIGH_MIN+1+SETUP_CYC cycles.
- R8: On a write, bus_oe is 1 for the whole access and bus_out equals the write data when the strobe rises. bus_oe falls after DATA_HOLD high cycles. On a read, bus_oe stays 0.
- R9: On a read, the value on bus_in in the cycle ready is taken appears on rd_data with a one-cycle done pulse. err is 0 in that case.
- R10: If TMO_EN is set and rdy_n stays high for TMO_CYC cycles after the minimum low time, the strobe rises after exactly LOW_MIN+TMO_CYC low cycles. done then pulses with err set to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Sequencer idle, request is taken this cycle |
| req_rnw | input | 1 | 1 for read, 0 for write |
| req_ctl | input | 2 | Control code placed on the select group |
| req_half | input | 1 | Halfword-select bit |
| req_wdata | input | DW | Write data |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout flag, valid with done |
| rd_data | output | DW | Last captured read data |
| cs_n | output | 1 | Chip-select, active low |
| ds_a_n | output | 1 | Data strobe A, active low |
| ds_b_n | output | 1 | Data strobe B, active low |
| as_n | output | 1 | Address strobe, active low |
| sel_ctl | output | 2 | Control code to target |
| sel_rnw | output | 1 | Read/write select to target |
| sel_half | output | 1 | Halfword select to target |
| bus_out | output | DW | Data driven to target |
| bus_oe | output | 1 | Data bus output enable |
| bus_in | input | DW | Data returned by target |
| rdy_n | input | 1 | Target ready, active low |

## Verification
The assertions assume the target drops rdy_n only while the effective strobe is low, and releases it once the strobe is high again. They also assume that a request stays still while req_ready is low. The bench's responder process keeps to the first assumption: it drives rdy_n low only after a chosen number of strobe-low cycles and raises it as soon as the strobe goes high. The request tasks keep to the second, changing request fields only when req_ready is 1 or req_valid is 0.

// File: rtl/hpa_pkg.sv
package hpa_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STB_LOW,
    ST_WAIT_RDY,
    ST_RDY_HOLD,
    ST_RELEASE,
    ST_RECOVER
  } hpa_state_e;

  // Effective target strobe, active low.
  function automatic logic eff_strobe_n(input logic cs_n, input logic a_n, input logic b_n);
    return ~(a_n ^ b_n) | cs_n;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/hpa_cycle_timer.sv
module hpa_cycle_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/hpa_pin_driver.sv
module hpa_pin_driver #(
  parameter int STB_SEL = 0
) (
  input  logic acc_on,
  input  logic stb_on,
  output logic cs_n,
  output logic ds_a_n,
  output logic ds_b_n
);
  assign cs_n = ~acc_on;

  // One data-strobe line pulses, the other is parked high.
  generate
    if (STB_SEL == 0) begin : g_line_a
      assign ds_a_n = ~stb_on;
      assign ds_b_n = 1'b1;
    end else begin : g_line_b
      assign ds_a_n = 1'b1;
      assign ds_b_n = ~stb_on;
    end
  endgenerate
endmodule

// File: rtl/hpa_strobe_seq.sv
module hpa_strobe_seq
  import hpa_pkg::*;
#(
  parameter int DW        = 16,
  parameter int SETUP_CYC = 2,
  parameter int LOW_MIN   = 4,
  parameter int RDY_HOLD  = 1,
  parameter int DATA_HOLD = 1,
  parameter int HIGH_MIN  = 4,
  parameter int TMO_CYC   = 16,
  parameter bit TMO_EN    = 1'b1,
  parameter int STB_SEL   = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_rnw,
  input  logic [1:0]    req_ctl,
  input  logic          req_half,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rd_data,
  output logic          cs_n,
  output logic          ds_a_n,
  output logic          ds_b_n,
  output logic          as_n,
  output logic [1:0]    sel_ctl,
  output logic          sel_rnw,
  output logic          sel_half,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  input  logic [DW-1:0] bus_in,
  input  logic          rdy_n
);
  localparam int MAXC = max_of(max_of(max_of(SETUP_CYC, LOW_MIN), max_of(RDY_HOLD, DATA_HOLD)),
                               max_of(HIGH_MIN, TMO_CYC));
  localparam int CW   = $clog2(MAXC + 1);

  function automatic logic [CW-1:0] span(input int n);
    return CW'(n - 1);
  endfunction

  hpa_state_e    st_q, st_d;
  logic          ld, expired;
  logic [CW-1:0] ld_val;
  logic          cmd_rnw, cmd_half;
  logic [1:0]    cmd_ctl;
  logic [DW-1:0] cmd_wdata, rd_q;
  logic          as_low_q, done_q, err_q, abort_q;
  logic          acc_on, stb_on;

  // Named internal events, also observed by the checker.
  logic accept, rdy_take, tmo_abort, last_release, eff_stb_n;
  assign accept       = req_valid && (st_q == ST_IDLE);
  assign rdy_take     = (st_q == ST_WAIT_RDY) && !rdy_n;
  assign tmo_abort    = TMO_EN && (st_q == ST_WAIT_RDY) && rdy_n && expired;
  assign last_release = (st_q == ST_RELEASE) && expired;

  always_comb begin
    st_d   = st_q;
    ld     = 1'b0;
    ld_val = '0;
    case (st_q)
      ST_IDLE:     if (req_valid) begin st_d = ST_SETUP;    ld = 1'b1; ld_val = span(SETUP_CYC); end
      ST_SETUP:    if (expired)   begin st_d = ST_STB_LOW;  ld = 1'b1; ld_val = span(LOW_MIN);   end
      ST_STB_LOW:  if (expired)   begin st_d = ST_WAIT_RDY; ld = 1'b1; ld_val = span(TMO_CYC);   end
      ST_WAIT_RDY: begin
        if (!rdy_n)         begin st_d = ST_RDY_HOLD; ld = 1'b1; ld_val = span(RDY_HOLD);  end
        else if (tmo_abort) begin st_d = ST_RELEASE;  ld = 1'b1; ld_val = span(DATA_HOLD); end
      end
      ST_RDY_HOLD: if (expired)   begin st_d = ST_RELEASE;  ld = 1'b1; ld_val = span(DATA_HOLD); end
      ST_RELEASE:  if (expired)   begin st_d = ST_RECOVER;  ld = 1'b1; ld_val = span(HIGH_MIN);  end
      ST_RECOVER:  if (expired)     st_d = ST_IDLE;
      default:                      st_d = ST_IDLE;
    endcase
  end

  hpa_cycle_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld),
    .load_val (ld_val),
    .expired  (expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cmd_rnw   <= 1'b1;
      cmd_ctl   <= '0;
      cmd_half  <= 1'b0;
      cmd_wdata <= '0;
      rd_q      <= '0;
      as_low_q  <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      abort_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        cmd_rnw   <= req_rnw;
        cmd_ctl   <= req_ctl;
        cmd_half  <= req_half;
        cmd_wdata <= req_wdata;
        abort_q   <= 1'b0;
      end
      if (tmo_abort) abort_q <= 1'b1;
      if (rdy_take && cmd_rnw) rd_q <= bus_in;
      if (st_q == ST_SETUP)        as_low_q <= 1'b1;
      else if (st_q == ST_RELEASE) as_low_q <= 1'b0;
      done_q <= last_release;
      err_q  <= last_release && abort_q;
    end
  end

  assign acc_on = (st_q == ST_SETUP) || (st_q == ST_STB_LOW) || (st_q == ST_WAIT_RDY) ||
                  (st_q == ST_RDY_HOLD) || (st_q == ST_RELEASE);
  assign stb_on = (st_q == ST_STB_LOW) || (st_q == ST_WAIT_RDY) || (st_q == ST_RDY_HOLD);

  hpa_pin_driver #(.STB_SEL(STB_SEL)) u_pins (
    .acc_on (acc_on),
    .stb_on (stb_on),
    .cs_n   (cs_n),
    .ds_a_n (ds_a_n),
    .ds_b_n (ds_b_n)
  );

  assign eff_stb_n = eff_strobe_n(cs_n, ds_a_n, ds_b_n);
  assign req_ready = (st_q == ST_IDLE);
  assign as_n      = ~as_low_q;
  assign sel_ctl   = cmd_ctl;
  assign sel_rnw   = cmd_rnw;
  assign sel_half  = cmd_half;
  assign bus_out   = cmd_wdata;
  assign bus_oe    = acc_on && !cmd_rnw;
  assign rd_data   = rd_q;
  assign done      = done_q;
  assign err       = err_q;
endmodule

// File: rtl/hpa_strobe_seq_chk.sv
module hpa_strobe_seq_chk #(
  parameter int LOW_MIN  = 4,
  parameter int HIGH_MIN = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       eff_stb_n,
  input logic       cs_n,
  input logic       as_n,
  input logic [1:0] sel_ctl,
  input logic       sel_rnw,
  input logic       sel_half,
  input logic       bus_oe,
  input logic       rdy_n,
  input logic       done,
  input logic       err,
  input logic       req_ready,
  input logic       tmo_abort
);
  logic [15:0] low_cnt, high_cnt;
  logic        rdy_seen;

  // Run-length counters replace long $past windows.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      high_cnt <= 16'hFFFF;
      rdy_seen <= 1'b0;
    end else begin
      low_cnt  <= eff_stb_n ? '0 : ((low_cnt == 16'hFFFF) ? low_cnt : low_cnt + 1'b1);
      high_cnt <= !eff_stb_n ? '0 : ((high_cnt == 16'hFFFF) ? high_cnt : high_cnt + 1'b1);
      rdy_seen <= eff_stb_n ? 1'b0 : (rdy_seen || !rdy_n);
    end
  end

  p_sel_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> ($stable(sel_ctl) && $stable(sel_rnw) && $stable(sel_half)));
  p_as_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !eff_stb_n |-> !as_n);
  p_low_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eff_stb_n) |-> (low_cnt >= 16'(LOW_MIN)));
  p_rise_after_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eff_stb_n) |-> (rdy_seen || $past(tmo_abort)));
  p_high_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eff_stb_n) |-> (high_cnt >= 16'(HIGH_MIN)));
  p_ready_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> cs_n);
  p_oe_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (!sel_rnw && !cs_n));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_err_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
endmodule

bind hpa_strobe_seq hpa_strobe_seq_chk #(.LOW_MIN(LOW_MIN), .HIGH_MIN(HIGH_MIN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .eff_stb_n (eff_stb_n),
  .cs_n      (cs_n),
  .as_n      (as_n),
  .sel_ctl   (sel_ctl),
  .sel_rnw   (sel_rnw),
  .sel_half  (sel_half),
  .bus_oe    (bus_oe),
  .rdy_n     (rdy_n),
  .done      (done),
  .err       (err),
  .req_ready (req_ready),
  .tmo_abort (tmo_abort)
);

// File: tb/sim_hpa_strobe_seq.sv
`timescale 1ns/1ps
module sim_hpa_strobe_seq;
  localparam int DW = 16, SETUP_CYC = 2, LOW_MIN = 4, RDY_HOLD = 1, DATA_HOLD = 1,
                 HIGH_MIN = 4, TMO_CYC = 16;
  localparam int NVEC = 6;
  // {rnw, ctl[1:0], half, wdata[15:0], rdy delay[7:0], read value[15:0]}
  localparam logic [43:0] VEC [NVEC] = '{
    {1'b0, 2'd0, 1'b0, 16'hA5C3, 8'd0,  16'h0000},
    {1'b1, 2'd1, 1'b1, 16'h0000, 8'd2,  16'h1234},
    {1'b0, 2'd2, 1'b1, 16'hFFFF, 8'd9,  16'h0000},
    {1'b1, 2'd3, 1'b0, 16'h0000, 8'd6,  16'h8001},
    {1'b1, 2'd0, 1'b1, 16'h0000, 8'd0,  16'h0000},
    {1'b0, 2'd3, 1'b0, 16'h0001, 8'd12, 16'h0000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_rnw = 1'b1, req_half = 1'b0;
  logic [1:0] req_ctl = '0;
  logic [DW-1:0] req_wdata = '0, bus_in = '0;
  logic rdy_n = 1'b1;
  logic req_ready, done, err, cs_n, ds_a_n, ds_b_n, as_n, sel_rnw, sel_half, bus_oe;
  logic [1:0] sel_ctl;
  logic [DW-1:0] rd_data, bus_out;

  always #4 clk = ~clk;

  hpa_strobe_seq #(.DW(DW), .SETUP_CYC(SETUP_CYC), .LOW_MIN(LOW_MIN), .RDY_HOLD(RDY_HOLD),
    .DATA_HOLD(DATA_HOLD), .HIGH_MIN(HIGH_MIN), .TMO_CYC(TMO_CYC), .TMO_EN(1'b1), .STB_SEL(0)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_rnw(req_rnw),
    .req_ctl(req_ctl), .req_half(req_half), .req_wdata(req_wdata), .done(done), .err(err),
    .rd_data(rd_data), .cs_n(cs_n), .ds_a_n(ds_a_n), .ds_b_n(ds_b_n), .as_n(as_n),
    .sel_ctl(sel_ctl), .sel_rnw(sel_rnw), .sel_half(sel_half), .bus_out(bus_out),
    .bus_oe(bus_oe), .bus_in(bus_in), .rdy_n(rdy_n));

  int total = 0, bad = 0;
  int cur_low = 0, last_low = 0, cur_high = 1000, last_high = 0, rhold = 0, last_rhold = 0;
  int rdy_dly = 0;
  logic [DW-1:0] rd_val = '0, data_at_rise = '0;
  logic prev_eff = 1'b1, prev_cs = 1'b1, sel_chg = 1'b0, b_low = 1'b0, oe_seen = 1'b0;
  logic as_at_fall = 1'b1, oe_at_rise = 1'b0, oe_after = 1'b0;
  logic [3:0] sel_at_fall = '0, prev_sel = '0;

  // Monitor and target responder, both on the falling edge.
  initial forever begin
    logic eff;
    @(negedge clk);
    eff = ~(ds_a_n ^ ds_b_n) | cs_n;
    if (!cs_n && prev_cs) begin sel_chg = 1'b0; b_low = 1'b0; oe_seen = 1'b0; end
    if (!cs_n && !prev_cs && ({sel_ctl, sel_rnw, sel_half} != prev_sel)) sel_chg = 1'b1;
    if (bus_oe) oe_seen = 1'b1;
    if (eff === 1'b0) begin
      if (prev_eff) begin
        last_high = cur_high; cur_high = 0; cur_low = 0; rhold = 0;
        sel_at_fall = {sel_ctl, sel_rnw, sel_half}; as_at_fall = as_n;
      end
      cur_low++;
      if (!rdy_n) rhold++;
      if (!ds_b_n) b_low = 1'b1;
    end else begin
      if (!prev_eff) begin
        last_low = cur_low; last_rhold = rhold; oe_at_rise = bus_oe; data_at_rise = bus_out;
      end
      if (cur_high < 100000) cur_high++;
      if (cur_high == 2) oe_after = bus_oe;
    end
    prev_eff = (eff === 1'b0) ? 1'b0 : 1'b1;
    prev_cs  = cs_n;
    prev_sel = {sel_ctl, sel_rnw, sel_half};
    if (eff === 1'b0 && cur_low >= rdy_dly) rdy_n = 1'b0;
    else if (eff !== 1'b0) rdy_n = 1'b1;
    bus_in = rd_val;
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic rnw, input logic [1:0] ctl, input logic half,
                       input logic [DW-1:0] wd, input int dly, input logic [DW-1:0] rdv);
    rdy_dly = dly; rd_val = rdv;
    while (!req_ready) step();
    req_rnw = rnw; req_ctl = ctl; req_half = half; req_wdata = wd; req_valid = 1'b1;
    step();
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int k = 0; k < 300 && !seen; k++) begin
      step();
      if (done) seen = 1'b1;
    end
  endtask

  task automatic run_all();
    bit seen;
    // R1: reset state
    repeat (3) step();
    chk(cs_n == 1'b1 && ds_a_n == 1'b1 && ds_b_n == 1'b1, "R1", "strobes in reset", {cs_n, ds_a_n, ds_b_n}, 3'b111);
    rst_n = 1'b1;
    repeat (2) step();
    chk(cs_n && ds_a_n && ds_b_n && as_n, "R1", "pins idle", {cs_n, ds_a_n, ds_b_n, as_n}, 4'hF);
    chk(bus_oe == 1'b0, "R1", "bus_oe idle", bus_oe, 0);
    chk(done == 1'b0, "R1", "done idle", done, 0);
    chk(req_ready == 1'b1, "R1", "req_ready idle", req_ready, 1);

    for (int i = 0; i < NVEC; i++) begin
      logic [43:0] v = VEC[i];
      issue(v[43], v[42:41], v[40], v[39:24], int'(v[23:16]), v[15:0]);
      wait_done(seen);
      chk(seen, "R9", "done pulse", seen, 1);
      chk(err == 1'b0, "R10", "no error with ready", err, 0);
      chk(req_ready == 1'b0, "R7", "not ready during recovery", req_ready, 0);
      chk(last_low >= LOW_MIN, "R5", "low width", last_low, LOW_MIN);
      chk(last_rhold >= RDY_HOLD, "R6", "low after ready", last_rhold, RDY_HOLD);
      chk(sel_at_fall == {v[42:41], v[43], v[40]} && !sel_chg, "R3", "selects", sel_at_fall, {v[42:41], v[43], v[40]});
      chk(as_at_fall == 1'b0, "R4", "as_n at strobe fall", as_at_fall, 0);
      chk(b_low == 1'b0, "R2", "idle strobe line", b_low, 0);
      if (v[43]) begin
        chk(rd_data == v[15:0], "R9", "read data", rd_data, v[15:0]);
        chk(oe_seen == 1'b0, "R8", "no drive on read", oe_seen, 0);
      end else begin
        chk(oe_at_rise && data_at_rise == v[39:24], "R8", "write data at rise", data_at_rise, v[39:24]);
        chk(oe_after == 1'b0, "R8", "drive released after hold", oe_after, 0);
      end
      step();
      chk(done == 1'b0, "R9", "done one cycle", done, 0);
    end

    // R10: target never ready
    issue(1'b1, 2'd2, 1'b0, '0, 255, 16'hBEEF);
    wait_done(seen);
    chk(seen && err == 1'b1, "R10", "timeout error", err, 1);
    chk(last_low == LOW_MIN + TMO_CYC, "R10", "timeout low length", last_low, LOW_MIN + TMO_CYC);
    chk(rd_data == 16'h0000, "R10", "read data kept", rd_data, 0);

    // R7: back-to-back requests give the exact high gap
    while (!req_ready) step();
    rdy_dly = 1; rd_val = 16'h00C0;
    req_rnw = 1'b1; req_ctl = 2'd1; req_half = 1'b0; req_valid = 1'b1;
    wait_done(seen);
    while (!req_ready) step();
    step();
    req_valid = 1'b0;
    wait_done(seen);
    chk(seen, "R9", "second done", seen, 1);
    chk(last_high == DATA_HOLD + HIGH_MIN + 1 + SETUP_CYC, "R7", "back-to-back gap",
        last_high, DATA_HOLD + HIGH_MIN + 1 + SETUP_CYC);
    chk(last_high >= HIGH_MIN, "R7", "min high", last_high, HIGH_MIN);
    repeat (10) step();
    chk(req_ready && cs_n, "R7", "idle after run", {req_ready, cs_n}, 2'b11);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL R9 watchdog: actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule